// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a word of N dual-rail bit pairs and reports on one single-rail signal when a four-phase computation has finished. The signal also reports when the word has gone back to the spacer. Each pair is turned into a per-bit valid flag. The flags are then reduced two ways. The all-valid term says every bit holds data. The any-valid term says that at least one bit has not yet returned to the spacer. A registered two-input Muller C-element joins the two terms into the acknowledge output.

The acknowledge rises only when the last bit becomes valid. It falls only when the last bit returns to the spacer. For any mix of valid bits and spacer bits it keeps its previous value. The block also decodes the data word. The decoded word is meaningful while the acknowledge is high. A sticky flag records any pair that shows both rails high. The model is synchronous: rails are sampled on the clock edge, and the C-element state is held in a flip-flop.

Top module: `drc_completion_detect`

## Requirements
- R1: Pair i occupies rails_i[2i+1:2i], and its valid flag is the OR of its two rails. all_valid_o is high, combinationally, exactly when every pair is nonzero.
- R2: any_valid_o is high, combinationally, exactly when at least one pair is nonzero. It stays high until every pair is back at the 00 spacer.
- R3: After a clock edge at which all_valid_o and any_valid_o are both high, ack_o is 1.
- R4: After a clock edge at which all_valid_o and any_valid_o are both low, ack_o is 0.
- R5: After a clock edge at which the two terms differ, ack_o keeps its previous value. This holds for any partial mix of valid and spacer pairs, in either phase.
- R6: Pair code 10 means data 1 and code 01 means data 0. data_o[i] equals rails_i[2i+1].
- R7: A pair at code 11 sampled on a clock edge sets proto_err_o after that edge. The flag stays set until reset. The illegal code still counts as valid for R1 and R2.
- R8: While rst_ni is low, ack_o and proto_err_o are 0. This holds whether reset is applied at start-up or in the middle of operation.
- R9: With all rails at 0 after reset, all_valid_o, any_valid_o and ack_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rails_i | input | 2*N | Dual-rail word, pair i at [2i+1:2i], bit 2i+1 is the true rail |
| data_o | output | N | Decoded data word |
| all_valid_o | output | 1 | Every pair carries a code |
| any_valid_o | output | 1 | At least one pair carries a code |
| ack_o | output | 1 | C-element state, the single-rail completion signal |
| proto_err_o | output | 1 | Sticky flag for a pair that showed code 11 |

## Verification
The bench makes bits valid in a shuffled order and expects ack_o to stay low until the final bit arrives. A design that used the OR term as the completion signal would acknowledge on the first bit instead. Bits are then returned to the spacer in a shuffled order, and ack_o must stay high until the final bit clears. A design that reset on the AND term would drop the acknowledge early. Partial mixes are held for several cycles in both phases to catch a C-element that does not keep its state, and one-hot data patterns catch swapped rails. An illegal pair is shown for a single cycle to prove that the error flag is sticky and that only reset clears it.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [1:0] {
    RAIL_SPACER  = 2'b00,
    RAIL_ZERO    = 2'b01,
    RAIL_ONE     = 2'b10,
    RAIL_ILLEGAL = 2'b11
  } rail_code_e;

  typedef enum logic {
    RED_AND = 1'b0,
    RED_OR  = 1'b1
  } red_op_e;

endpackage

// File: rtl/drc_rail_decode.sv
module drc_rail_decode #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] rails_i,
  output logic [N-1:0]   valid_o,
  output logic [N-1:0]   data_o,
  output logic [N-1:0]   illegal_o
);
  import drc_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    rail_code_e code;
    assign code         = rail_code_e'(rails_i[2*i +: 2]);
    assign valid_o[i]   = rails_i[2*i+1] | rails_i[2*i];
    assign data_o[i]    = rails_i[2*i+1];
    assign illegal_o[i] = (code == RAIL_ILLEGAL);
  end

endmodule

// File: rtl/drc_tree_reduce.sv
// Balanced log-depth reduction; pads unused leaves with the operator identity.
module drc_tree_reduce #(
  parameter int               N  = 8,
  parameter drc_pkg::red_op_e OP = drc_pkg::RED_AND
) (
  input  logic [N-1:0] in_i,
  output logic         out_o
);
  import drc_pkg::*;

  localparam int  LEVELS = (N <= 1) ? 0 : $clog2(N);
  localparam int  P      = 1 << LEVELS;
  localparam logic PAD   = (OP == RED_AND);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int LW = P >> l;
    logic [LW-1:0] v;
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < LW; j++) begin : g_pad
        if (j < N) begin : g_in
          assign v[j] = in_i[j];
        end else begin : g_fill
          assign v[j] = PAD;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < LW; j++) begin : g_op
        if (OP == RED_AND) begin : g_and
          assign v[j] = g_lvl[l-1].v[2*j] & g_lvl[l-1].v[2*j+1];
        end else begin : g_or
          assign v[j] = g_lvl[l-1].v[2*j] | g_lvl[l-1].v[2*j+1];
        end
      end
    end
  end

  assign out_o = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/drc_c_element.sv
module drc_c_element (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (a_i && b_i)        q_d = 1'b1;
    else if (!a_i && !b_i) q_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  a_r3_set_on_both_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i && b_i) |=> q_o);
  a_r4_clear_on_both_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_i && !b_i) |=> !q_o);
  a_r5_hold_on_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i != b_i) |=> $stable(q_o));

endmodule

// File: rtl/drc_completion_detect.sv
module drc_completion_detect #(
  parameter int N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*N-1:0] rails_i,
  output logic [N-1:0]   data_o,
  output logic           all_valid_o,
  output logic           any_valid_o,
  output logic           ack_o,
  output logic           proto_err_o
);
  import drc_pkg::*;

  logic [N-1:0] bit_valid;
  logic [N-1:0] bit_illegal;
  logic         err_q;

  drc_rail_decode #(.N(N)) u_decode (
    .rails_i  (rails_i),
    .valid_o  (bit_valid),
    .data_o   (data_o),
    .illegal_o(bit_illegal)
  );

  drc_tree_reduce #(.N(N), .OP(RED_AND)) u_done (
    .in_i (bit_valid),
    .out_o(all_valid_o)
  );

  drc_tree_reduce #(.N(N), .OP(RED_OR)) u_reset (
    .in_i (bit_valid),
    .out_o(any_valid_o)
  );

  drc_c_element u_cel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (all_valid_o),
    .b_i   (any_valid_o),
    .q_o   (ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          err_q <= 1'b0;
    else if (|bit_illegal) err_q <= 1'b1;
  end

  assign proto_err_o = err_q;

  a_r1_all_implies_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_valid_o |-> any_valid_o);
  a_r7_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bit_illegal) |=> proto_err_o);
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
  a_r6_data_needs_valid_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|data_o) |-> any_valid_o);

endmodule

// File: tb/tb_drc_completion_detect.sv
module tb_drc_completion_detect;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [2*W-1:0] rails = '0;
  logic [W-1:0]   data_o;
  logic           all_valid_o, any_valid_o, ack_o, proto_err_o;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done_flag = 1'b0;
  logic  ack_exp = 1'b0;
  logic  err_exp = 1'b0;
  string ack_tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  drc_completion_detect #(.N(W)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rails_i    (rails),
    .data_o     (data_o),
    .all_valid_o(all_valid_o),
    .any_valid_o(any_valid_o),
    .ack_o      (ack_o),
    .proto_err_o(proto_err_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] enc(input logic d);
    return d ? 2'b10 : 2'b01;
  endfunction

  // Drive at negedge, check outputs, advance the expected C-element state.
  task automatic apply(input logic [2*W-1:0] v);
    logic a, o;
    logic [W-1:0] d;
    logic ill;
    @(negedge clk);
    rails = v;
    #1;
    chk(ack_o === ack_exp, ack_tag, ack_o, ack_exp);
    chk(proto_err_o === err_exp, "R7", proto_err_o, err_exp);
    a = 1'b1; o = 1'b0; ill = 1'b0;
    for (int i = 0; i < W; i++) begin
      a &= (v[2*i +: 2] != 2'b00);
      o |= (v[2*i +: 2] != 2'b00);
      ill |= (v[2*i +: 2] == 2'b11);
      d[i] = v[2*i+1];
    end
    chk(all_valid_o === a, "R1", all_valid_o, a);
    chk(any_valid_o === o, "R2", any_valid_o, o);
    chk(data_o === d, "R6", data_o, d);
    if (a && o)        begin ack_exp = 1'b1; ack_tag = "R3"; end
    else if (!a && !o) begin ack_exp = 1'b0; ack_tag = "R4"; end
    else               ack_tag = "R5";
    if (ill) err_exp = 1'b1;
  endtask

  task automatic shuffle(ref int ord[W]);
    for (int i = 0; i < W; i++) ord[i] = i;
    for (int i = W-1; i > 0; i--) begin
      int j, t;
      j = int'($urandom_range(i, 0));
      t = ord[i]; ord[i] = ord[j]; ord[j] = t;
    end
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    rails = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(ack_o === 1'b0, "R8", ack_o, 0);
    chk(proto_err_o === 1'b0, "R8", proto_err_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    ack_exp = 1'b0; err_exp = 1'b0; ack_tag = "R9";
    apply('0);
    apply('0);
    chk({all_valid_o, any_valid_o, ack_o} === 3'b000, "R9", {all_valid_o, any_valid_o, ack_o}, 0);
  endtask

  // R3: rises only on the last valid bit.
  task automatic t_rise_random(input logic [W-1:0] word);
    int ord[W];
    logic [2*W-1:0] v = '0;
    shuffle(ord);
    for (int k = 0; k < W; k++) begin
      v[2*ord[k] +: 2] = enc(word[ord[k]]);
      apply(v);
      if (k < W-1) begin
        apply(v);
        chk(ack_o === 1'b0, "R5 early rise", ack_o, 0);
      end
    end
    apply(v);
    chk(ack_o === 1'b1, "R3", ack_o, 1);
    chk(data_o === word, "R6", data_o, word);
  endtask

  // R4: falls only when the last bit returns to spacer.
  task automatic t_fall_random();
    int ord[W];
    logic [2*W-1:0] v = rails;
    shuffle(ord);
    for (int k = 0; k < W; k++) begin
      v[2*ord[k] +: 2] = 2'b00;
      apply(v);
      if (k < W-1) begin
        apply(v);
        chk(ack_o === 1'b1, "R5 early fall", ack_o, 1);
      end
    end
    apply(v);
    chk(ack_o === 1'b0, "R4", ack_o, 0);
  endtask

  task automatic t_hold_mix();
    logic [2*W-1:0] v;
    v = '0;
    v[1:0] = 2'b10; v[7:6] = 2'b01;
    repeat (3) apply(v);
    chk(ack_o === 1'b0, "R5 hold low", ack_o, 0);
    v = '0;
    for (int i = 0; i < W; i++) v[2*i +: 2] = enc(i[0]);
    apply(v); apply(v);
    v[5:4] = 2'b00; v[2*W-1 -: 2] = 2'b00;
    repeat (3) apply(v);
    chk(ack_o === 1'b1, "R5 hold high", ack_o, 1);
    apply('0); apply('0);
  endtask

  task automatic t_illegal();
    logic [2*W-1:0] v = '0;
    v[7:6] = 2'b11;
    apply(v);
    chk(any_valid_o === 1'b1, "R7 illegal counts valid", any_valid_o, 1);
    apply('0);
    repeat (2) apply('0);
    chk(proto_err_o === 1'b1, "R7 sticky", proto_err_o, 1);
    for (int i = 0; i < W; i++) v[2*i +: 2] = 2'b01;
    apply(v); apply(v);
    chk(ack_o === 1'b1, "R3", ack_o, 1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(ack_o === 1'b0, "R8 mid-run", ack_o, 0);
    chk(proto_err_o === 1'b0, "R8 mid-run", proto_err_o, 0);
    rails = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    ack_exp = 1'b0; err_exp = 1'b0; ack_tag = "R8";
    apply('0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    t_reset_state();
    t_rise_random(8'hA5);
    t_fall_random();
    t_rise_random(8'h00);
    t_fall_random();
    t_rise_random(8'hFF);
    t_fall_random();
    for (int b = 0; b < W; b++) begin
      t_rise_random(W'(1) << b);
      t_fall_random();
    end
    t_hold_mix();
    t_illegal();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule